// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block sits between a load/store unit and the memory system. For each data access it turns the virtual address into a physical address, decides whether the target is uncacheable, and judges whether the access is legal. The request carries the virtual address, the access size, a store flag, a physical-mode flag, a page-table-walk flag, an instruction-fetch flag, the current privilege mode, a privileged-code flag with an alternate-mode select and value, the current address-space number, and a flag from upstream logic that says whether the virtual address is well formed.

The block does not hold the translation buffer. It presents the virtual page number and address-space number on a lookup interface. In the same cycle it receives a hit flag, the physical page number, per-mode read and write enable masks, and the fault-on-read and fault-on-write bits. The checks run in a fixed order and only the earliest failing check is reported. The response is registered and comes out one cycle after the request. It carries a fault code, a six-bit status mask, the physical address and an uncacheable flag.

The encodings are as follows. Fault codes: 0 none, 1 alignment, 2 page fault, 3 access violation, 4 page-table miss, 5 normal miss, 6 machine check, 7 unimplemented. Status bits: bit 0 store, bit 1 access violation, bit 2 bad virtual address, bit 3 miss, bit 4 fault-on-read, bit 5 fault-on-write. Modes: 0 kernel, 1 executive, 2 supervisor, 3 user. Bit m of each enable mask grants mode m. The page offset is 13 bits wide, the implemented physical width is 44 bits, and the superpage tag is virtual address bits 47:41 equal to 7'h7e.

Top module: `data_xlate_check`

## Requirements
- R1: A request sampled with req_valid high produces rsp_valid high on the next clock. A cycle with req_valid low, or any cycle in reset, produces rsp_valid low with fault, status and address all zero.
- R2: Alignment is checked first, in physical mode too. If vaddr & (size-1) is nonzero the result is fault 1 and the status holds only bit 0, which equals the store flag. This check takes priority over an invalid virtual address.
- R3: In physical mode the physical address equals the virtual address. The validity flag, the superpage rule and the lookup result have no effect.
- R4: Outside physical mode, an invalid virtual address gives fault 2 with status bits 1 and 2 set, plus bit 0 on a store. This holds even when the lookup reports a hit.
- R5: A superpage access (vaddr[47:41] = 7'h7e) is legal only when cur_mode is kernel. Otherwise it gives fault 3 with status bit 1, plus bit 0 on a store. The rule reads cur_mode, not the effective mode, and the lookup is not consulted.
- R6: A legal superpage access maps to vaddr[43:0]. If bit 40 of that value is set, bits 43:40 become all ones; otherwise they become zero.
- R7: A lookup miss gives fault 4 when the walk flag is set and fault 5 otherwise. Both set status bit 3, plus bit 0 on a store.
- R8: A store that hits faults with code 2 if the write-enable bit for the effective mode is clear. The status is then bits 0 and 1, plus bit 5 if the entry's fault-on-write bit is set. If the enable bit is set but fault-on-write is set, the result is fault 2 with status bits 0 and 5. The fault-on-read bit has no effect on stores.
- R9: A load that hits gives fault 3 if the read-enable bit for the effective mode is clear. The status is then bit 1, plus bit 4 if fault-on-read is set. If the enable bit is set but fault-on-read is set, the result is fault 2 with status bit 4 alone.
- R10: The effective mode is cur_mode when priv_code is low. When priv_code is high it is kernel, unless alt_sel is high, in which case it is alt_mode.
- R11: On a hit the physical address is {ppn, vaddr[12:0]}.
- R12: If the physical address from any path has a bit set at position 44 or above, the result is fault 6 with zero status.
- R13: If physical address bit 43 is set, the access is uncacheable: rsp_uncached is 1 and address bits 42:35 are cleared. If the instruction-fetch flag is also set, the result is fault 7 with zero status.
- R14: Whenever the fault code is nonzero, rsp_paddr is zero and rsp_uncached is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | Store when high, load when low |
| req_phys | input | 1 | Physical mode: bypass translation |
| req_walk | input | 1 | Access belongs to a page-table walk |
| req_ifetch | input | 1 | Access is an instruction fetch |
| req_va_ok | input | 1 | Virtual address is well formed |
| cur_mode | input | 2 | Current privilege mode |
| priv_code | input | 1 | Privileged code is running |
| alt_sel | input | 1 | Use the alternate mode under privileged code |
| alt_mode | input | 2 | Alternate mode value |
| cur_asn | input | 8 | Current address-space number |
| lk_vpn | output | 51 | Virtual page number sent to the lookup |
| lk_asn | output | 8 | Address-space number sent to the lookup |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_ppn | input | 32 | Physical page number of the entry |
| lk_rd_en | input | 4 | Per-mode read enable mask |
| lk_wr_en | input | 4 | Per-mode write enable mask |
| lk_fonr | input | 1 | Entry fault-on-read bit |
| lk_fonw | input | 1 | Entry fault-on-write bit |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 44 | Physical address (zero on fault) |
| rsp_uncached | output | 1 | Access targets uncacheable space |
| rsp_fault | output | 3 | Fault code |
| rsp_stat | output | 6 | Memory-management status mask |

## Verification
Two cases are hard to reach from the ports. The first is a translated physical address with bit 43 set, so that the superpage sign extension and the uncacheable clearing act on the same access. The second is a machine check on the translated path. The stimulus reaches the first with a kernel superpage whose bit 40 is set. It reaches the second with a page number whose top bit puts the result at bit 44. Some vectors present conflicting conditions on purpose, such as a misaligned invalid address, an invalid address with a lookup hit, or a superpage under privileged code with a user alternate mode. These confirm that only the earliest check in the order wins. Reset asserted during an active request shows that the registered response clears.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [2:0] {
    FLT_NONE      = 3'd0,
    FLT_ALIGN     = 3'd1,
    FLT_PAGE      = 3'd2,
    FLT_ACV       = 3'd3,
    FLT_MISS_WALK = 3'd4,
    FLT_MISS_NORM = 3'd5,
    FLT_MCHK      = 3'd6,
    FLT_UNIMP     = 3'd7
  } flt_e;

  localparam int ST_W     = 6;
  localparam int ST_WR    = 0;
  localparam int ST_ACV   = 1;
  localparam int ST_BADVA = 2;
  localparam int ST_MISS  = 3;
  localparam int ST_FONR  = 4;
  localparam int ST_FONW  = 5;

  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_KERNEL = 2'd0;

endpackage

// File: rtl/dtc_front.sv
// Alignment test and effective-mode selection.
module dtc_front
  import dtc_pkg::*;
#(
  parameter int SZ_W = 4
) (
  input  logic [SZ_W-1:0]   va_low,
  input  logic [SZ_W-1:0]   size,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic              priv_code,
  input  logic              alt_sel,
  input  logic [MODE_W-1:0] alt_mode,
  output logic              misalign,
  output logic [MODE_W-1:0] eff_mode
);

  logic [SZ_W-1:0] size_mask;

  always_comb begin
    size_mask = size - SZ_W'(1);
    misalign  = |(va_low & size_mask);
    if (!priv_code)   eff_mode = cur_mode;
    else if (alt_sel) eff_mode = alt_mode;
    else              eff_mode = MODE_KERNEL;
  end

endmodule

// File: rtl/dtc_xlate.sv
// Address path: physical bypass, validity, superpage, lookup result, permissions.
module dtc_xlate
  import dtc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int XW         = 64,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 'h7e,
  parameter int SP_SIGN    = 40
) (
  input  logic [VA_W-1:0]     vaddr,
  input  logic                write,
  input  logic                phys,
  input  logic                walk,
  input  logic                va_ok,
  input  logic [MODE_W-1:0]   cur_mode,
  input  logic [MODE_W-1:0]   eff_mode,
  input  logic                lk_hit,
  input  logic [PPN_W-1:0]    lk_ppn,
  input  logic [(1<<MODE_W)-1:0] lk_rd_en,
  input  logic [(1<<MODE_W)-1:0] lk_wr_en,
  input  logic                lk_fonr,
  input  logic                lk_fonw,
  output logic [XW-1:0]       pa_raw,
  output flt_e                flt,
  output logic [ST_W-1:0]     stat
);

  localparam int SP_TAG_W = SP_HI - SP_LO + 1;
  localparam int EXT_W    = PA_W - SP_SIGN;

  logic          is_super;
  logic [XW-1:0] super_pa;
  logic [XW-1:0] tlb_pa;
  logic [XW-1:0] phys_pa;

  always_comb begin
    is_super = (vaddr[SP_HI:SP_LO] == SP_TAG_W'(SP_TAG));
    super_pa = '0;
    super_pa[PA_W-1:0] = vaddr[PA_W-1:0];
    super_pa[PA_W-1:SP_SIGN] = {EXT_W{vaddr[SP_SIGN]}};
    tlb_pa  = XW'({lk_ppn, vaddr[PAGE_SHIFT-1:0]});
    phys_pa = XW'(vaddr);
  end

  always_comb begin
    pa_raw = '0;
    flt    = FLT_NONE;
    stat   = '0;
    if (phys) begin
      pa_raw = phys_pa;
    end else if (!va_ok) begin
      flt            = FLT_PAGE;
      stat[ST_WR]    = write;
      stat[ST_ACV]   = 1'b1;
      stat[ST_BADVA] = 1'b1;
    end else if (is_super) begin
      if (cur_mode != MODE_KERNEL) begin
        flt          = FLT_ACV;
        stat[ST_WR]  = write;
        stat[ST_ACV] = 1'b1;
      end else begin
        pa_raw = super_pa;
      end
    end else if (!lk_hit) begin
      flt           = walk ? FLT_MISS_WALK : FLT_MISS_NORM;
      stat[ST_WR]   = write;
      stat[ST_MISS] = 1'b1;
    end else begin
      pa_raw = tlb_pa;
      if (write) begin
        if (!lk_wr_en[eff_mode]) begin
          flt           = FLT_PAGE;
          stat[ST_WR]   = 1'b1;
          stat[ST_ACV]  = 1'b1;
          stat[ST_FONW] = lk_fonw;
        end else if (lk_fonw) begin
          flt           = FLT_PAGE;
          stat[ST_WR]   = 1'b1;
          stat[ST_FONW] = 1'b1;
        end
      end else begin
        if (!lk_rd_en[eff_mode]) begin
          flt           = FLT_ACV;
          stat[ST_ACV]  = 1'b1;
          stat[ST_FONR] = lk_fonr;
        end else if (lk_fonr) begin
          flt           = FLT_PAGE;
          stat[ST_FONR] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dtc_pa_check.sv
// Final physical-address checks: implemented width, uncacheable space.
module dtc_pa_check
  import dtc_pkg::*;
#(
  parameter int PA_W      = 44,
  parameter int XW        = 64,
  parameter int UC_CLR_LO = 35
) (
  input  logic [XW-1:0]   pa_raw,
  input  flt_e            flt_in,
  input  logic [ST_W-1:0] stat_in,
  input  logic            ifetch,
  output logic [PA_W-1:0] pa_out,
  output logic            uncached,
  output flt_e            flt,
  output logic [ST_W-1:0] stat
);

  localparam int CLR_W = PA_W - 1 - UC_CLR_LO;

  logic            over_width;
  logic            uc_bit;
  logic [PA_W-1:0] pa_clr;

  always_comb begin
    over_width = |pa_raw[XW-1:PA_W];
    uc_bit     = pa_raw[PA_W-1];
    pa_clr     = pa_raw[PA_W-1:0];
    if (uc_bit) pa_clr[PA_W-2:UC_CLR_LO] = {CLR_W{1'b0}};
  end

  always_comb begin
    pa_out   = '0;
    uncached = 1'b0;
    flt      = flt_in;
    stat     = stat_in;
    if (flt_in == FLT_NONE) begin
      if (over_width) begin
        flt  = FLT_MCHK;
        stat = '0;
      end else if (uc_bit && ifetch) begin
        flt  = FLT_UNIMP;
        stat = '0;
      end else begin
        pa_out   = pa_clr;
        uncached = uc_bit;
      end
    end
  end

endmodule

// File: rtl/data_xlate_check.sv
module data_xlate_check
  import dtc_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PA_W       = 44,
  parameter int PAGE_SHIFT = 13,
  parameter int PPN_W      = 32,
  parameter int ASN_W      = 8,
  parameter int SZ_W       = 4,
  parameter int SP_HI      = 47,
  parameter int SP_LO      = 41,
  parameter int SP_TAG     = 'h7e,
  parameter int SP_SIGN    = 40,
  parameter int UC_CLR_LO  = 35
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [SZ_W-1:0]         req_size,
  input  logic                    req_write,
  input  logic                    req_phys,
  input  logic                    req_walk,
  input  logic                    req_ifetch,
  input  logic                    req_va_ok,
  input  logic [1:0]              cur_mode,
  input  logic                    priv_code,
  input  logic                    alt_sel,
  input  logic [1:0]              alt_mode,
  input  logic [ASN_W-1:0]        cur_asn,
  output logic [VA_W-PAGE_SHIFT-1:0] lk_vpn,
  output logic [ASN_W-1:0]        lk_asn,
  input  logic                    lk_hit,
  input  logic [PPN_W-1:0]        lk_ppn,
  input  logic [3:0]              lk_rd_en,
  input  logic [3:0]              lk_wr_en,
  input  logic                    lk_fonr,
  input  logic                    lk_fonw,
  output logic                    rsp_valid,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic                    rsp_uncached,
  output logic [2:0]              rsp_fault,
  output logic [5:0]              rsp_stat
);

  localparam int XW = (VA_W > PPN_W + PAGE_SHIFT) ? VA_W : PPN_W + PAGE_SHIFT;

  logic              misalign;
  logic [MODE_W-1:0] eff_mode;
  logic [XW-1:0]     xl_pa;
  flt_e              xl_flt;
  logic [ST_W-1:0]   xl_stat;
  flt_e              pre_flt;
  logic [ST_W-1:0]   pre_stat;
  logic [PA_W-1:0]   fin_pa;
  logic              fin_uc;
  flt_e              fin_flt;
  logic [ST_W-1:0]   fin_stat;

  assign lk_vpn = req_vaddr[VA_W-1:PAGE_SHIFT];
  assign lk_asn = cur_asn;

  dtc_front #(.SZ_W(SZ_W)) u_front (
    .va_low    (req_vaddr[SZ_W-1:0]),
    .size      (req_size),
    .cur_mode  (cur_mode),
    .priv_code (priv_code),
    .alt_sel   (alt_sel),
    .alt_mode  (alt_mode),
    .misalign  (misalign),
    .eff_mode  (eff_mode)
  );

  dtc_xlate #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .PPN_W(PPN_W),
    .XW(XW), .SP_HI(SP_HI), .SP_LO(SP_LO), .SP_TAG(SP_TAG), .SP_SIGN(SP_SIGN)
  ) u_xlate (
    .vaddr    (req_vaddr),
    .write    (req_write),
    .phys     (req_phys),
    .walk     (req_walk),
    .va_ok    (req_va_ok),
    .cur_mode (cur_mode),
    .eff_mode (eff_mode),
    .lk_hit   (lk_hit),
    .lk_ppn   (lk_ppn),
    .lk_rd_en (lk_rd_en),
    .lk_wr_en (lk_wr_en),
    .lk_fonr  (lk_fonr),
    .lk_fonw  (lk_fonw),
    .pa_raw   (xl_pa),
    .flt      (xl_flt),
    .stat     (xl_stat)
  );

  // Alignment outranks every other check.
  always_comb begin
    if (misalign) begin
      pre_flt         = FLT_ALIGN;
      pre_stat        = '0;
      pre_stat[ST_WR] = req_write;
    end else begin
      pre_flt  = xl_flt;
      pre_stat = xl_stat;
    end
  end

  dtc_pa_check #(.PA_W(PA_W), .XW(XW), .UC_CLR_LO(UC_CLR_LO)) u_pachk (
    .pa_raw   (xl_pa),
    .flt_in   (pre_flt),
    .stat_in  (pre_stat),
    .ifetch   (req_ifetch),
    .pa_out   (fin_pa),
    .uncached (fin_uc),
    .flt      (fin_flt),
    .stat     (fin_stat)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid    <= 1'b0;
      rsp_paddr    <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= FLT_NONE;
      rsp_stat     <= '0;
    end else begin
      rsp_valid    <= 1'b1;
      rsp_paddr    <= fin_pa;
      rsp_uncached <= fin_uc;
      rsp_fault    <= fin_flt;
      rsp_stat     <= fin_stat;
    end
  end

endmodule

// File: rtl/data_xlate_check_sva.sv
module data_xlate_check_sva
  import dtc_pkg::*;
#(
  parameter int PA_W      = 44,
  parameter int UC_CLR_LO = 35
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_uncached,
  input logic [2:0]      rsp_fault,
  input logic [5:0]      rsp_stat
);

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_stat == '0 && rsp_paddr == '0));

  // R2
  align_stat_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fault != 3'd1 || rsp_stat == ST_W'($past(req_write))));

  // R7
  miss_stat_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_stat[ST_MISS] == (rsp_fault == 3'd4 || rsp_fault == 3'd5)));

  // R13
  uncached_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_uncached |-> (rsp_paddr[PA_W-1] && rsp_paddr[PA_W-2:UC_CLR_LO] == '0));

  // R14
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != 3'd0) |-> (rsp_paddr == '0 && !rsp_uncached));

endmodule

bind data_xlate_check data_xlate_check_sva #(.PA_W(PA_W), .UC_CLR_LO(UC_CLR_LO)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_uncached (rsp_uncached),
  .rsp_fault    (rsp_fault),
  .rsp_stat     (rsp_stat)
);

// File: tb/data_xlate_check_bench.sv
module data_xlate_check_bench;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [7:0]  tag;
    logic [63:0] va;
    logic [3:0]  sz;
    logic        wr, ph, wk, ix;
    logic [1:0]  cm;
    logic        pv, asel;
    logic [1:0]  am;
    logic        vok, hit;
    logic [31:0] ppn;
    logic [3:0]  rde, wre;
    logic        fr, fw;
    logic [2:0]  ef;
    logic [5:0]  es;
    logic [43:0] ep;
    logic        eu;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VT [NV] = '{
    // R2 misaligned store
    '{8'd2, 64'h1003, 4'd4, 1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd1,6'h01,44'h0,1'b0},
    // R2 misaligned in physical mode
    '{8'd2, 64'h5, 4'd2, 1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd1,6'h00,44'h0,1'b0},
    // R2 alignment outranks invalid address
    '{8'd2, 64'h3, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b0,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd1,6'h00,44'h0,1'b0},
    // R3 physical mode ignores validity and lookup
    '{8'd3, 64'h1_2345_6780, 4'd8, 1'b0,1'b1,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b0,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h1_2345_6780,1'b0},
    // R4 invalid load despite hit
    '{8'd4, 64'h8000, 4'd8, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b0,1'b1, 32'h5,4'hf,4'hf,1'b0,1'b0, 3'd2,6'h06,44'h0,1'b0},
    // R4 invalid store
    '{8'd4, 64'h8000, 4'd8, 1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b0,1'b1, 32'h5,4'hf,4'hf,1'b0,1'b0, 3'd2,6'h07,44'h0,1'b0},
    // R5 superpage from user mode
    '{8'd5, 64'hFC00_0000_0000, 4'd8, 1'b0,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd3,6'h02,44'h0,1'b0},
    // R5 privileged code does not lift the superpage rule
    '{8'd5, 64'hFC00_0000_0000, 4'd8, 1'b1,1'b0,1'b0,1'b0, 2'd3,1'b1,1'b0,2'd0, 1'b1,1'b1, 32'h0,4'hf,4'hf,1'b0,1'b0, 3'd3,6'h03,44'h0,1'b0},
    // R6 kernel superpage, bit 40 clear
    '{8'd6, 64'hFC12_3456_7000, 4'd8, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h012_3456_7000,1'b0},
    // R6 bit 40 set extends, then R13 strips; user alternate mode ignored (R5)
    '{8'd6, 64'hFD12_3456_7000, 4'd8, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b1,2'd3, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h802_3456_7000,1'b1},
    // R7 normal miss on load
    '{8'd7, 64'h4000, 4'd8, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd5,6'h08,44'h0,1'b0},
    // R7 walk miss on store
    '{8'd7, 64'h4000, 4'd8, 1'b1,1'b0,1'b1,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd4,6'h09,44'h0,1'b0},
    // R11 hit address composition
    '{8'd11, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'h1,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h246_8abc,1'b0},
    // R9 load denied with fault-on-read
    '{8'd9, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'h1,4'hf,1'b1,1'b0, 3'd3,6'h12,44'h0,1'b0},
    // R9 load allowed but fault-on-read
    '{8'd9, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'h8,4'h0,1'b1,1'b0, 3'd2,6'h10,44'h0,1'b0},
    // R9 load denied, no fault-on-read
    '{8'd9, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'h1,4'hf,1'b0,1'b1, 3'd3,6'h02,44'h0,1'b0},
    // R8 store denied with fault-on-write
    '{8'd8, 64'h2_0abc, 4'd4, 1'b1,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'hf,4'h1,1'b0,1'b1, 3'd2,6'h23,44'h0,1'b0},
    // R8 store allowed but fault-on-write
    '{8'd8, 64'h2_0abc, 4'd4, 1'b1,1'b0,1'b0,1'b0, 2'd3,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'hf,4'h8,1'b0,1'b1, 3'd2,6'h21,44'h0,1'b0},
    // R8 store allowed, fault-on-read has no effect
    '{8'd8, 64'h2_0abc, 4'd4, 1'b1,1'b0,1'b0,1'b0, 2'd2,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h1234,4'h0,4'h4,1'b1,1'b0, 3'd0,6'h00,44'h246_8abc,1'b0},
    // R10 privileged code with alternate user mode
    '{8'd10, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b1,1'b1,2'd3, 1'b1,1'b1, 32'h1234,4'h1,4'h0,1'b0,1'b0, 3'd3,6'h02,44'h0,1'b0},
    // R10 privileged code without alternate runs as kernel
    '{8'd10, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd3,1'b1,1'b0,2'd3, 1'b1,1'b1, 32'h1234,4'h1,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h246_8abc,1'b0},
    // R12 translated address beyond implemented width
    '{8'd12, 64'h2_0abc, 4'd4, 1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b1, 32'h8000_0000,4'hf,4'h0,1'b0,1'b0, 3'd6,6'h00,44'h0,1'b0},
    // R12 physical address beyond implemented width
    '{8'd12, 64'h1000_0000_0000, 4'd8, 1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd6,6'h00,44'h0,1'b0},
    // R13 physical uncacheable strip
    '{8'd13, 64'h8FF_8000_1000, 4'd8, 1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h807_8000_1000,1'b1},
    // R13 fetch from uncacheable space, R14 zeroed outputs
    '{8'd13, 64'h8FF_8000_1000, 4'd8, 1'b0,1'b1,1'b0,1'b1, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd7,6'h00,44'h0,1'b0},
    // R13 fetch from cacheable space is fine
    '{8'd13, 64'h1000, 4'd8, 1'b0,1'b1,1'b0,1'b1, 2'd0,1'b0,1'b0,2'd0, 1'b1,1'b0, 32'h0,4'h0,4'h0,1'b0,1'b0, 3'd0,6'h00,44'h1000,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_phys, req_walk, req_ifetch, req_va_ok;
  logic [63:0] req_vaddr;
  logic [3:0]  req_size;
  logic [1:0]  cur_mode, alt_mode;
  logic        priv_code, alt_sel;
  logic [7:0]  cur_asn;
  logic [50:0] lk_vpn;
  logic [7:0]  lk_asn;
  logic        lk_hit, lk_fonr, lk_fonw;
  logic [31:0] lk_ppn;
  logic [3:0]  lk_rd_en, lk_wr_en;
  logic        rsp_valid, rsp_uncached;
  logic [43:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  data_xlate_check u_data_xlate_check (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_size(req_size), .req_write(req_write), .req_phys(req_phys),
    .req_walk(req_walk), .req_ifetch(req_ifetch), .req_va_ok(req_va_ok),
    .cur_mode(cur_mode), .priv_code(priv_code), .alt_sel(alt_sel),
    .alt_mode(alt_mode), .cur_asn(cur_asn), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
    .lk_fonr(lk_fonr), .lk_fonw(lk_fonw), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
    .rsp_stat(rsp_stat)
  );

  task automatic drive(input vec_t v);
    req_valid  = 1'b1;
    req_vaddr  = v.va;   req_size  = v.sz;
    req_write  = v.wr;   req_phys  = v.ph;
    req_walk   = v.wk;   req_ifetch = v.ix;
    cur_mode   = v.cm;   priv_code = v.pv;
    alt_sel    = v.asel; alt_mode  = v.am;
    req_va_ok  = v.vok;  lk_hit    = v.hit;
    lk_ppn     = v.ppn;  lk_rd_en  = v.rde;
    lk_wr_en   = v.wre;  lk_fonr   = v.fr;
    lk_fonw    = v.fw;
  endtask

  task automatic check_rsp(input int tag, input logic ev, input logic [2:0] ef,
                           input logic [5:0] es, input logic [43:0] ep, input logic eu);
    n_chk++;
    if (rsp_valid !== ev || rsp_fault !== ef || rsp_stat !== es ||
        rsp_paddr !== ep || rsp_uncached !== eu) begin
      n_fail++;
      $display("FAIL R%0d actual v=%0b f=%0d s=%h pa=%h uc=%0b expected v=%0b f=%0d s=%h pa=%h uc=%0b",
               tag, rsp_valid, rsp_fault, rsp_stat, rsp_paddr, rsp_uncached,
               ev, ef, es, ep, eu);
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_size = 4'd8;
    req_write = 1'b0; req_phys = 1'b0; req_walk = 1'b0; req_ifetch = 1'b0;
    req_va_ok = 1'b1; cur_mode = 2'd0; priv_code = 1'b0; alt_sel = 1'b0;
    alt_mode = 2'd0; cur_asn = 8'h5a; lk_hit = 1'b0; lk_ppn = '0;
    lk_rd_en = '0; lk_wr_en = '0; lk_fonr = 1'b0; lk_fonw = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_rsp(1, 1'b0, 3'd0, 6'h00, 44'h0, 1'b0);
    rst = 1'b0;

    // R1 lookup interface carries page number and address space
    drive(VT[12]);
    #1;
    n_chk++;
    if (lk_vpn !== 51'h10 || lk_asn !== 8'h5a) begin
      n_fail++;
      $display("FAIL R1 actual vpn=%h asn=%h expected vpn=10 asn=5a", lk_vpn, lk_asn);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      @(negedge clk);
      check_rsp(int'(VT[i].tag), 1'b1, VT[i].ef, VT[i].es, VT[i].ep, VT[i].eu);
    end

    // R1 idle cycle clears the response
    req_valid = 1'b0;
    @(negedge clk);
    check_rsp(1, 1'b0, 3'd0, 6'h00, 44'h0, 1'b0);

    // R1 reset during an active request
    drive(VT[12]);
    rst = 1'b1;
    @(negedge clk);
    check_rsp(1, 1'b0, 3'd0, 6'h00, 44'h0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    // R11 request resumes after reset
    check_rsp(11, 1'b1, 3'd0, 6'h00, 44'h246_8abc, 1'b0);

    req_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule